// File: doc/BRIEF.md
# Programmable Trigger Coincidence Unit

This block turns four discriminated trigger lines into trigger pulses for a strip-detector readout system. Two of the lines come from photomultiplier channels, the other two from an external positive-pulse and negative-pulse discriminator. Each line is synchronised to the 40 MHz system clock, and only its rising edge counts. A per-line enable mask chooses which sources take part. A mode bit decides how the two photomultiplier channels combine. With the bit clear, either channel alone triggers. With the bit set, their edges must fall within a programmable window of 0 to 3 clocks.

A qualified trigger always produces a one-cycle external trigger pulse. If no previous trigger is still waiting, the same trigger also produces an internal trigger pulse and starts a countdown equal to the analogue pipeline latency of the front-end chip. When the countdown ends, a one-cycle trigger request goes to the chip's fast control. A trigger that arrives while a countdown is running is not forwarded, and it increments a saturating counter of dropped triggers.

Separately, the block emits a one-cycle start reference every four clocks (100 ns at 40 MHz) for an external time-to-digital converter.

Top module: `trig_coinc_unit`

## Requirements
- R1: While reset is high and in the first cycle after it is released, all pulse outputs are low and the dropped-trigger count is zero.
- R2: Bit 0 of `trig_raw_i` is photomultiplier A, bit 1 is photomultiplier B, bit 2 is the positive pulse and bit 3 is the negative pulse. Only a rising edge triggers, so a line held high yields a single trigger. If a line is first high when sampled at clock edge k, `trig_ext_o` is high in the cycle after edge k+2.
- R3: A line whose bit in `cfg_enable_i` is 0 never causes a trigger.
- R4: With `cfg_coinc_i` = 0, an enabled rising edge on either photomultiplier line triggers on its own.
- R5: With `cfg_coinc_i` = 1, photomultiplier edges trigger only when both channels are enabled and the edges are at most `cfg_window_i` cycles apart. The trigger is issued on the later edge, and both edges are then used up. An edge with no partner inside the window produces nothing.
- R6: `start_o` is a one-cycle pulse every 4 clocks. It is first high in the cycle after the 4th clock edge following reset release.
- R7: `fc_trig_o` is a one-cycle pulse exactly 128 cycles after each `trig_int_o` pulse.
- R8: A trigger whose `trig_ext_o` pulse falls in the cycles after a `trig_int_o` pulse, up to and including the cycle of the matching `fc_trig_o` pulse, produces no `trig_int_o`. Each such trigger increments `drop_count_o` by one, and the count saturates at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_raw_i | input | 4 | Asynchronous discriminated trigger lines |
| cfg_enable_i | input | 4 | Per-line enable mask |
| cfg_coinc_i | input | 1 | 1 = photomultiplier coincidence required |
| cfg_window_i | input | WIN_W | Coincidence window in clocks |
| trig_ext_o | output | 1 | External trigger pulse, one per qualified trigger |
| trig_int_o | output | 1 | Accepted trigger that starts the latency countdown |
| fc_trig_o | output | 1 | Delayed trigger request to the front-end fast control |
| start_o | output | 1 | Periodic start reference for the time converter |
| drop_count_o | output | DROP_W | Saturating count of triggers dropped during a countdown |

## Verification
The bench feeds random, independently toggling levels on all four lines with coincidence off. Since every edge counts in that run, it tests the synchroniser delay and the edge detection. Directed photomultiplier pairs are then applied with the second edge offset by 0 to 4 cycles, under several window settings and in both edge orders. These pairs show where the window boundary lies, and they show that a lone edge is ignored. Random runs with partial enable masks test the masking in both coincidence modes. A dense pulse train on the positive line fills each countdown with rejected triggers, which exercises the drop window boundary and drives the small bench-sized counter into saturation.

// File: rtl/trig_coinc_pkg.sv
package trig_coinc_pkg;
  localparam int NUM_LINES = 4;
  localparam int LINE_PMA  = 0;
  localparam int LINE_PMB  = 1;
  localparam int LINE_POS  = 2;
  localparam int LINE_NEG  = 3;

  typedef logic [NUM_LINES-1:0] line_vec_t;
endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] rise_o
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_line
      logic [STAGES-1:0] chain_q;
      logic              prev_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          chain_q <= '0;
          prev_q  <= 1'b0;
        end else begin
          chain_q <= {chain_q[STAGES-2:0], raw_i[g]};
          prev_q  <= chain_q[STAGES-1];
        end
      end
      assign rise_o[g] = chain_q[STAGES-1] & ~prev_q;

      AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_o[g] |=> !rise_o[g]); // R2
    end
  endgenerate
endmodule

// File: rtl/trig_pm_coinc.sv
module trig_pm_coinc #(
  parameter int WIN_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [3:0]           rise_i,
  input  logic [3:0]           enable_i,
  input  logic                 coinc_i,
  input  logic [WIN_W-1:0]     window_i,
  output logic                 fire_o
);
  import trig_coinc_pkg::*;
  localparam int AGE_W = WIN_W + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(2**WIN_W);

  logic [1:0]            hold_q;
  logic [1:0][AGE_W-1:0] age_q;
  logic [1:0]            near;
  logic                  hit;
  logic                  pm_fire;
  logic                  ext_fire;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_near
      assign near[g] = hold_q[g] && (age_q[g] <= {1'b0, window_i});
    end
  endgenerate

  assign hit = (rise_i[LINE_PMA] && rise_i[LINE_PMB]) ||
               (rise_i[LINE_PMA] && near[1]) ||
               (rise_i[LINE_PMB] && near[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      age_q  <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (hit) begin
          hold_q[i] <= 1'b0;
          age_q[i]  <= '0;
        end else if (rise_i[i]) begin
          hold_q[i] <= 1'b1;
          age_q[i]  <= AGE_W'(1);
        end else if (hold_q[i] && age_q[i] != AGE_MAX) begin
          age_q[i]  <= age_q[i] + AGE_W'(1);
        end
      end
    end
  end

  always_comb begin
    if (coinc_i)
      pm_fire = hit && enable_i[LINE_PMA] && enable_i[LINE_PMB];
    else
      pm_fire = (rise_i[LINE_PMA] && enable_i[LINE_PMA]) ||
                (rise_i[LINE_PMB] && enable_i[LINE_PMB]);
    ext_fire = (rise_i[LINE_POS] && enable_i[LINE_POS]) ||
               (rise_i[LINE_NEG] && enable_i[LINE_NEG]);
  end

  assign fire_o = pm_fire || ext_fire;

  AST_COINC_PAIR: assert property (@(posedge clk) disable iff (rst)
    (coinc_i && hit) |-> ((rise_i[LINE_PMA] || hold_q[0]) && (rise_i[LINE_PMB] || hold_q[1]))); // R5
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (enable_i == 4'b0000) |-> !fire_o); // R3
endmodule

// File: rtl/trig_latency.sv
module trig_latency #(
  parameter int LATENCY = 128,
  parameter int DROP_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire_i,
  output logic              accept_o,
  output logic              fc_o,
  output logic [DROP_W-1:0] drop_o
);
  localparam int LAT_W = $clog2(LATENCY);
  localparam logic [LAT_W-1:0] LOAD = LAT_W'(LATENCY - 1);

  logic             busy_q;
  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      accept_o <= 1'b0;
      fc_o     <= 1'b0;
      drop_o   <= '0;
    end else begin
      accept_o <= fire_i && !busy_q;
      fc_o     <= 1'b0;
      if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          fc_o   <= 1'b1;
        end else begin
          cnt_q  <= cnt_q - LAT_W'(1);
        end
        if (fire_i && drop_o != '1)
          drop_o <= drop_o + DROP_W'(1);
      end else if (fire_i) begin
        busy_q <= 1'b1;
        cnt_q  <= LOAD;
      end
    end
  end

  AST_FC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fc_o |=> !fc_o); // R7
  AST_FC_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != '0) |=> !fc_o); // R7
  AST_DROP_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy_q && fire_i && drop_o != '1) |=> (drop_o == $past(drop_o) + DROP_W'(1))); // R8
  AST_DROP_SAT: assert property (@(posedge clk) disable iff (rst)
    (drop_o == '1) |=> (drop_o == '1)); // R8
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> !accept_o); // R8
endmodule

// File: rtl/trig_start_gen.sv
module trig_start_gen #(
  parameter int PERIOD = 4
) (
  input  logic clk,
  input  logic rst,
  output logic start_o
);
  localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      start_o <= 1'b0;
    end else begin
      start_o <= (cnt_q == LAST);
      cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
    end
  end

  AST_START_GAP: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o); // R6
endmodule

// File: rtl/trig_coinc_unit.sv
module trig_coinc_unit #(
  parameter int SYNC_STAGES  = 2,
  parameter int LATENCY      = 128,
  parameter int START_PERIOD = 4,
  parameter int WIN_W        = 2,
  parameter int DROP_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        trig_raw_i,
  input  logic [3:0]        cfg_enable_i,
  input  logic              cfg_coinc_i,
  input  logic [WIN_W-1:0]  cfg_window_i,
  output logic              trig_ext_o,
  output logic              trig_int_o,
  output logic              fc_trig_o,
  output logic              start_o,
  output logic [DROP_W-1:0] drop_count_o
);
  import trig_coinc_pkg::*;

  line_vec_t rise;
  logic      fire;

  trig_sync_edge #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw_i(trig_raw_i), .rise_o(rise)
  );

  trig_pm_coinc #(.WIN_W(WIN_W)) u_coinc (
    .clk(clk), .rst(rst), .rise_i(rise), .enable_i(cfg_enable_i),
    .coinc_i(cfg_coinc_i), .window_i(cfg_window_i), .fire_o(fire)
  );

  trig_latency #(.LATENCY(LATENCY), .DROP_W(DROP_W)) u_lat (
    .clk(clk), .rst(rst), .fire_i(fire), .accept_o(trig_int_o),
    .fc_o(fc_trig_o), .drop_o(drop_count_o)
  );

  trig_start_gen #(.PERIOD(START_PERIOD)) u_start (
    .clk(clk), .rst(rst), .start_o(start_o)
  );

  always_ff @(posedge clk) begin
    if (rst) trig_ext_o <= 1'b0;
    else     trig_ext_o <= fire;
  end

  AST_INT_HAS_EXT: assert property (@(posedge clk) disable iff (rst)
    trig_int_o |-> trig_ext_o); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!trig_ext_o && !trig_int_o && !fc_trig_o && !start_o && drop_count_o == '0)); // R1
endmodule

// File: tb/trig_coinc_unit_bench.sv
module trig_coinc_unit_bench;
  localparam int LAT   = 128;
  localparam int DW    = 4;
  localparam int DMAX  = 15;
  localparam int DEPTH = 256;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] raw = 4'b0;
  logic [3:0] cfg_en = 4'hF;
  logic       cfg_co = 1'b0;
  logic [1:0] cfg_w = 2'd0;
  logic       trig_ext, trig_int, fc_trig, start;
  logic [DW-1:0] drop_cnt;

  always #5 clk = ~clk;

  trig_coinc_unit #(.DROP_W(DW)) u_trig_coinc_unit (
    .clk(clk), .rst(rst), .trig_raw_i(raw), .cfg_enable_i(cfg_en),
    .cfg_coinc_i(cfg_co), .cfg_window_i(cfg_w), .trig_ext_o(trig_ext),
    .trig_int_o(trig_int), .fc_trig_o(fc_trig), .start_o(start),
    .drop_count_o(drop_cnt)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;
  string tag = "R4";

  bit exp_ext [DEPTH];
  bit exp_int [DEPTH];
  bit exp_fc  [DEPTH];
  int exp_drop[DEPTH];

  logic [3:0] m_prev = 4'b0;
  bit m_hold[2];
  int m_age[2];
  int m_last_acc = -100000;
  int m_drop = 0;

  task automatic chk(string req, int act, int expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
    end
  endtask

  function automatic bit start_expected(int c);
    return (c > 0) && (c % 4 == 0);
  endfunction

  task automatic model(int t, logic [3:0] v);
    logic [3:0] e;
    bit nr0, nr1, hit, pmf, fire;
    int idx;
    e = v & ~m_prev;
    m_prev = v;
    nr0 = m_hold[0] && (m_age[0] <= int'(cfg_w));
    nr1 = m_hold[1] && (m_age[1] <= int'(cfg_w));
    hit = (e[0] && e[1]) || (e[0] && nr1) || (e[1] && nr0);
    for (int i = 0; i < 2; i++) begin
      if (hit) begin m_hold[i] = 0; m_age[i] = 0; end
      else if (e[i]) begin m_hold[i] = 1; m_age[i] = 1; end
      else if (m_hold[i] && m_age[i] < 4) m_age[i]++;
    end
    if (cfg_co) pmf = hit && cfg_en[0] && cfg_en[1];
    else        pmf = (e[0] && cfg_en[0]) || (e[1] && cfg_en[1]);
    fire = pmf || (e[2] && cfg_en[2]) || (e[3] && cfg_en[3]);
    idx = (t + 3) % DEPTH;
    exp_ext[idx] = fire;
    exp_int[idx] = 0;
    if (fire) begin
      if (t > m_last_acc + LAT) begin
        exp_int[idx] = 1;
        exp_fc[(t + 3 + LAT) % DEPTH] = 1;
        m_last_acc = t;
      end else if (m_drop < DMAX) begin
        m_drop++;
      end
    end
    exp_drop[idx] = m_drop;
  endtask

  task automatic check_cycle();
    int idx;
    idx = cyc % DEPTH;
    chk(tag,  trig_ext, exp_ext[idx]);
    chk("R8", trig_int, exp_int[idx]);
    chk("R7", fc_trig,  exp_fc[idx]);
    chk("R6", start,    start_expected(cyc));
    chk("R8", drop_cnt, exp_drop[idx]);
    exp_fc[idx] = 0;
  endtask

  task automatic step(logic [3:0] v);
    @(negedge clk);
    cyc++;
    check_cycle();
    raw = v;
    model(cyc, v);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(4'b0);
  endtask

  task automatic pair(int off, bit b_first);
    for (int k = 0; k < off + 3; k++) begin
      logic [3:0] v;
      bit a_on, b_on;
      a_on = (k < 2);
      b_on = (k >= off) && (k < off + 2);
      v = 4'b0;
      v[0] = b_first ? b_on : a_on;
      v[1] = b_first ? a_on : b_on;
      step(v);
    end
    idle(140);
  endtask

  task automatic rand_run(int n);
    logic [3:0] lvl;
    lvl = 4'b0;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 4; b++)
        if ($urandom % 6 == 0) lvl[b] = ~lvl[b];
      step(lvl);
    end
    idle(10);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    void'($urandom(32'd20061));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    chk("R1", trig_ext, 0);
    chk("R1", trig_int, 0);
    chk("R1", fc_trig, 0);
    chk("R1", start, 0);
    chk("R1", drop_cnt, 0);
    raw = 4'b0;
    model(0, 4'b0);

    // R2: a line held high gives exactly one trigger
    tag = "R2";
    cfg_en = 4'hF; cfg_co = 0; cfg_w = 0;
    for (int i = 0; i < 20; i++) step(4'b0100);
    idle(140);

    // R4: random levels, coincidence off, all lines enabled
    tag = "R4";
    rand_run(400);
    idle(140);

    // R5: directed photomultiplier pairs around the window edge
    tag = "R5";
    cfg_co = 1;
    for (int w = 0; w < 4; w++) begin
      cfg_w = 2'(w);
      idle(8);
      for (int off = 0; off <= w + 1; off++) begin
        pair(off, 1'b0);
        pair(off, 1'b1);
      end
    end
    step(4'b0001); idle(140);
    rand_run(300);
    idle(140);

    // R3: partial enable masks in both modes
    tag = "R3";
    cfg_co = 0; cfg_en = 4'b0110;
    idle(8);
    rand_run(300);
    cfg_co = 1; cfg_en = 4'b1001; cfg_w = 2'd3;
    idle(8);
    rand_run(300);
    idle(140);

    // R8: dense pulse train drives drops into saturation
    tag = "R8";
    cfg_co = 0; cfg_en = 4'b0100;
    idle(8);
    for (int i = 0; i < 300; i++) step((i % 2 == 0) ? 4'b0100 : 4'b0000);
    idle(140);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R7: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule